// File: doc/BRIEF.md
# Legacy Keyboard Controller Host Register Interface

This block is the software-facing half of a two-channel keyboard/mouse host controller. A host bus reads and writes single bytes at two addresses. The data address carries bytes in both directions. The control address returns a status byte on reads and accepts a controller command on writes. Behind these addresses the block holds:

- one byte waiting for the host;
- one byte waiting for a device;
- a 32-byte scratch RAM whose byte 0 is the configuration byte;
- an output-port register.

The device side is two byte streams, each with a valid/ready handshake in each direction. Serial line framing is not part of this block.

Both device-side interfaces follow valid/ready rules. Outgoing bytes are offered on exactly one port and held stable until that port's ready is high on a clock edge. An incoming byte is taken when valid and ready are both high. Ready drops while the host-side byte is occupied, so a device stalls until the host reads. A port whose clock-disable bit is set keeps ready high and its bytes are discarded. Self-test and line-test outcomes come from plain stub inputs. The interrupt outputs and the four active-low pulse lines are plain level outputs.

Top module: `kbc_host_regs`

## Requirements
- R1: A read at address 0x64 returns status with these bits: bit 0 = host-side byte full, bit 1 = device-side byte full, bit 2 = configuration bit 2, bit 3 = 1 if the last accepted write was a command and 0 if it was data, bit 6 = `dev_timeout`, bit 7 = `dev_parity`, and bits 4 and 5 = 0. A read at 0x60 returns the host-side byte. Any other address reads 0.
- R2: A data write (address 0x60) with no pending two-byte command is offered to port 1. Status bit 1 stays set until the port accepts the byte, and the byte is held stable meanwhile. A data write for a device while status bit 1 is set is dropped. At most one port is offered a byte at a time.
- R3: After command 0xD4, the next data write is offered to port 2 instead of port 1.
- R4: Command 0x20+N (N = 0..31) loads RAM byte N into the host-side byte. Command 0x60+N stores the next data write into RAM byte N. RAM byte 0 is the configuration byte, and its bits 3 and 7 always read 0.
- R5: Commands 0xAD and 0xAE set and clear configuration bit 4 (port 1 disabled). Commands 0xA7 and 0xA8 set and clear configuration bit 5 (port 2 disabled). A disabled port's incoming bytes are accepted and discarded.
- R6: Command 0xAA returns 0x55 when `selftest_ok` is 1 and 0xFC when it is 0. Commands 0xAB and 0xA9 return the 3-bit line code of port 1 and port 2 respectively, zero-extended to a byte.
- R7: `ctrl_outport` shows the output-port register after reset value 0x01. Bit 4 is replaced by "host-side byte full and from port 1" and bit 5 by "host-side byte full and from port 2". Command 0xD1 stores the next data write into the register. Command 0xD0 returns the live output-port value.
- R8: Commands 0xD2 and 0xD3 place the next data write into the host-side byte, marked as coming from port 1 or port 2 respectively.
- R9: `irq_p1` is high exactly while a port-1 byte is waiting and configuration bit 0 is set. `irq_p2` is high exactly while a port-2 byte is waiting and configuration bit 1 is set.
- R10: Command 0xF0 to 0xFE drives low, for PULSE_CYC cycles, each `pulse_n` line whose command bit (bits 3:0) is 0. Command 0xFF pulses nothing.
- R11: A data read empties the host-side byte. Device bytes are taken only while it is empty. Port 1 wins when both ports offer a byte. A controller response replaces any waiting byte.
- R12: A command byte outside the listed set changes no state. This includes the pending two-byte command and status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host address (0x60 or 0x64) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| p1_tx_valid | output | 1 | Byte offered to port 1 |
| p1_tx_ready | input | 1 | Port 1 accepts |
| p1_tx_data | output | 8 | Byte to port 1 |
| p2_tx_valid | output | 1 | Byte offered to port 2 |
| p2_tx_ready | input | 1 | Port 2 accepts |
| p2_tx_data | output | 8 | Byte to port 2 |
| p1_rx_valid | input | 1 | Port 1 has a byte |
| p1_rx_ready | output | 1 | Controller takes port 1 byte |
| p1_rx_data | input | 8 | Byte from port 1 |
| p2_rx_valid | input | 1 | Port 2 has a byte |
| p2_rx_ready | output | 1 | Controller takes port 2 byte |
| p2_rx_data | input | 8 | Byte from port 2 |
| irq_p1 | output | 1 | Port 1 interrupt |
| irq_p2 | output | 1 | Port 2 interrupt |
| ctrl_outport | output | 8 | Live output-port value |
| pulse_n | output | 4 | Active-low timed pulse lines, line 0 = system reset |
| selftest_ok | input | 1 | Stub controller self-test outcome |
| p1_line_code | input | 3 | Stub port 1 line-test code |
| p2_line_code | input | 3 | Stub port 2 line-test code |
| dev_timeout | input | 1 | Time-out error flag |
| dev_parity | input | 1 | Parity error flag |

## Verification
The bench attacks the following corner cases:

- **Second data write while the device-side byte is still held.** A design that overwrote the held byte would change `p1_tx_data` mid-handshake.
- **Both ports offering a byte at once.** A wrong arbiter would take port 2 first or lose the port-1 byte.
- **Configuration bits 3 and 7 written as ones.** A design without masking would read them back set.
- **Disabled port's bytes.** A design that did not discard them would fill the host-side byte and raise an interrupt.
- **Unlisted command placed between 0xD4 and its data byte.** A design that cleared the pending redirect would send the byte to port 1.
- **Pulse-width edges.** A counter off by one shows up as a pulse one cycle too long or too short.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W    = 8;
  localparam int RAM_DEPTH = 32;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);
  localparam int LINES     = 4;
  localparam logic [BYTE_W-1:0] CFG_RW_MASK = 8'h77;

  typedef enum logic [1:0] {SRC_CTRL, SRC_P1, SRC_P2} src_e;
  typedef enum logic [2:0] {PD_NONE, PD_RAMW, PD_OUTP, PD_LOOP1, PD_LOOP2, PD_TOP2} pend_e;
  typedef enum logic [2:0] {RK_NONE, RK_RAM, RK_SELF, RK_LINE1, RK_LINE2, RK_OUTP} resp_e;

  typedef struct packed {
    logic              known;
    resp_e             resp;
    logic [RAM_AW-1:0] idx;
    pend_e             pend;
    logic [BYTE_W-1:0] cfg_set;
    logic [BYTE_W-1:0] cfg_clr;
    logic              pulse_go;
    logic [LINES-1:0]  pulse_lines;
  } cmd_dec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output cmd_dec_t          dec
);
  always_comb begin
    dec       = '0;
    dec.resp  = RK_NONE;
    dec.pend  = PD_NONE;
    dec.idx   = cmd[RAM_AW-1:0];
    if (cmd[7:5] == 3'b001) begin
      dec.known = 1'b1;
      dec.resp  = RK_RAM;
    end else if (cmd[7:5] == 3'b011) begin
      dec.known = 1'b1;
      dec.pend  = PD_RAMW;
    end else if (cmd[7:4] == 4'hF) begin
      dec.known       = 1'b1;
      dec.pulse_lines = ~cmd[LINES-1:0];
      dec.pulse_go    = |(~cmd[LINES-1:0]);
    end else begin
      dec.known = 1'b1;
      case (cmd)
        8'hAD: dec.cfg_set = 8'h10;
        8'hAE: dec.cfg_clr = 8'h10;
        8'hA7: dec.cfg_set = 8'h20;
        8'hA8: dec.cfg_clr = 8'h20;
        8'hAA: dec.resp    = RK_SELF;
        8'hAB: dec.resp    = RK_LINE1;
        8'hA9: dec.resp    = RK_LINE2;
        8'hD0: dec.resp    = RK_OUTP;
        8'hD1: dec.pend    = PD_OUTP;
        8'hD2: dec.pend    = PD_LOOP1;
        8'hD3: dec.pend    = PD_LOOP2;
        8'hD4: dec.pend    = PD_TOP2;
        default: dec.known = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kbc_pulse_gen.sv
module kbc_pulse_gen #(
  parameter int unsigned PULSE_CYC = 600000,
  parameter int          LINES     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LINES-1:0] lines,
  output logic [LINES-1:0] line_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  logic [CW-1:0]    cnt;
  logic [LINES-1:0] act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= '0;
    end else if (go) begin
      cnt <= CW'(PULSE_CYC);
      act <= lines;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) act <= '0;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_n[g] = ~act[g];
  end
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 600000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        p1_tx_valid,
  input  logic        p1_tx_ready,
  output logic [7:0]  p1_tx_data,
  output logic        p2_tx_valid,
  input  logic        p2_tx_ready,
  output logic [7:0]  p2_tx_data,
  input  logic        p1_rx_valid,
  output logic        p1_rx_ready,
  input  logic [7:0]  p1_rx_data,
  input  logic        p2_rx_valid,
  output logic        p2_rx_ready,
  input  logic [7:0]  p2_rx_data,
  output logic        irq_p1,
  output logic        irq_p2,
  output logic [7:0]  ctrl_outport,
  output logic [3:0]  pulse_n,
  input  logic        selftest_ok,
  input  logic [2:0]  p1_line_code,
  input  logic [2:0]  p2_line_code,
  input  logic        dev_timeout,
  input  logic        dev_parity
);
  localparam logic [7:0] ADDR_DATA = 8'h60;
  localparam logic [7:0] ADDR_CTRL = 8'h64;

  logic              rx_full, tx_full, tx_to_p2, last_cmd;
  logic [BYTE_W-1:0] rx_data, tx_data, outp_q, resp_byte, cfg, status, outp_live;
  src_e              rx_src;
  pend_e             pend;
  logic [RAM_AW-1:0] pend_idx;
  logic [BYTE_W-1:0] ram [RAM_DEPTH];
  cmd_dec_t          dec;

  kbc_cmd_decode u_dec (.cmd(host_wdata), .dec(dec));

  logic wr_cmd, wr_dat, rd_dat, cmd_ok, resp_load, loop_load, ctrl_load;
  logic p1_off, p2_off, p1_take, p2_take, tx_done, to_dev;

  assign cfg       = ram[0];
  assign wr_cmd    = host_wr && (host_addr == ADDR_CTRL);
  assign wr_dat    = host_wr && (host_addr == ADDR_DATA);
  assign rd_dat    = host_rd && (host_addr == ADDR_DATA);
  assign cmd_ok    = wr_cmd && dec.known;
  assign resp_load = cmd_ok && (dec.resp != RK_NONE);
  assign loop_load = wr_dat && ((pend == PD_LOOP1) || (pend == PD_LOOP2));
  assign ctrl_load = resp_load || loop_load;
  assign to_dev    = wr_dat && ((pend == PD_NONE) || (pend == PD_TOP2));

  assign p1_off      = cfg[4];
  assign p2_off      = cfg[5];
  assign p1_rx_ready = p1_off || (!rx_full && !ctrl_load);
  assign p2_rx_ready = p2_off || (!rx_full && !ctrl_load && !(p1_rx_valid && !p1_off));
  assign p1_take     = p1_rx_valid && p1_rx_ready && !p1_off;
  assign p2_take     = p2_rx_valid && p2_rx_ready && !p2_off;

  assign outp_live = {outp_q[7:6], rx_full && (rx_src == SRC_P2),
                      rx_full && (rx_src == SRC_P1), outp_q[3:0]};
  assign ctrl_outport = outp_live;
  assign irq_p1 = outp_live[4] && cfg[0];
  assign irq_p2 = outp_live[5] && cfg[1];

  always_comb begin
    case (dec.resp)
      RK_RAM:   resp_byte = ram[dec.idx];
      RK_SELF:  resp_byte = selftest_ok ? 8'h55 : 8'hFC;
      RK_LINE1: resp_byte = {5'b0, p1_line_code};
      RK_LINE2: resp_byte = {5'b0, p2_line_code};
      RK_OUTP:  resp_byte = outp_live;
      default:  resp_byte = '0;
    endcase
  end

  assign status = {dev_parity, dev_timeout, 2'b00, last_cmd, cfg[2], tx_full, rx_full};
  assign host_rdata = (host_addr == ADDR_CTRL) ? status :
                      (host_addr == ADDR_DATA) ? rx_data : '0;

  assign p1_tx_valid = tx_full && !tx_to_p2;
  assign p2_tx_valid = tx_full && tx_to_p2;
  assign p1_tx_data  = tx_data;
  assign p2_tx_data  = tx_data;
  assign tx_done     = (p1_tx_valid && p1_tx_ready) || (p2_tx_valid && p2_tx_ready);

  // host-side holding byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_data <= '0;
      rx_src  <= SRC_CTRL;
    end else begin
      if (rd_dat) rx_full <= 1'b0;
      if (p1_take) begin
        rx_full <= 1'b1; rx_data <= p1_rx_data; rx_src <= SRC_P1;
      end else if (p2_take) begin
        rx_full <= 1'b1; rx_data <= p2_rx_data; rx_src <= SRC_P2;
      end
      if (resp_load) begin
        rx_full <= 1'b1; rx_data <= resp_byte; rx_src <= SRC_CTRL;
      end else if (loop_load) begin
        rx_full <= 1'b1; rx_data <= host_wdata;
        rx_src  <= (pend == PD_LOOP1) ? SRC_P1 : SRC_P2;
      end
    end
  end

  // device-side holding byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_full  <= 1'b0;
      tx_data  <= '0;
      tx_to_p2 <= 1'b0;
    end else if (to_dev && !tx_full) begin
      tx_full  <= 1'b1;
      tx_data  <= host_wdata;
      tx_to_p2 <= (pend == PD_TOP2);
    end else if (tx_done) begin
      tx_full <= 1'b0;
    end
  end

  // command sequencing, output port and RAM
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= PD_NONE;
      pend_idx <= '0;
      last_cmd <= 1'b0;
      outp_q   <= 8'h01;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else if (cmd_ok) begin
      last_cmd <= 1'b1;
      pend     <= dec.pend;
      pend_idx <= dec.idx;
      ram[0]   <= (ram[0] | dec.cfg_set) & ~dec.cfg_clr;
    end else if (wr_dat) begin
      last_cmd <= 1'b0;
      pend     <= PD_NONE;
      if (pend == PD_OUTP) outp_q <= host_wdata;
      if (pend == PD_RAMW)
        ram[pend_idx] <= (pend_idx == '0) ? (host_wdata & CFG_RW_MASK) : host_wdata;
    end
  end

  kbc_pulse_gen #(.PULSE_CYC(PULSE_CYC), .LINES(LINES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .go(cmd_ok && dec.pulse_go),
    .lines(dec.pulse_lines), .line_n(pulse_n)
  );
endmodule

// File: rtl/kbc_host_regs_chk.sv
module kbc_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_full,
  input logic       host_rd,
  input logic       host_wr,
  input logic [7:0] host_addr,
  input logic       p1_rx_valid,
  input logic       p2_rx_valid,
  input logic       irq_p1,
  input logic       irq_p2,
  input logic       p1_tx_valid,
  input logic       p1_tx_ready,
  input logic [7:0] p1_tx_data,
  input logic       p2_tx_valid,
  input logic [7:0] cfg
);
  // R9
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_p1 || irq_p2) |-> rx_full);
  // R2
  one_tx_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_tx_valid && p2_tx_valid));
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_tx_valid && !p1_tx_ready) |=> (p1_tx_valid && $stable(p1_tx_data)));
  // R4
  cfg_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3] == 1'b0) && (cfg[7] == 1'b0));
  // R11
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_addr == 8'h60 && !p1_rx_valid && !p2_rx_valid) |=> !rx_full);
endmodule

bind kbc_host_regs kbc_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .host_rd(host_rd), .host_wr(host_wr),
  .host_addr(host_addr), .p1_rx_valid(p1_rx_valid), .p2_rx_valid(p2_rx_valid),
  .irq_p1(irq_p1), .irq_p2(irq_p2), .p1_tx_valid(p1_tx_valid), .p1_tx_ready(p1_tx_ready),
  .p1_tx_data(p1_tx_data), .p2_tx_valid(p2_tx_valid), .cfg(cfg)
);

// File: tb/kbc_host_regs_tb.sv
module kbc_host_regs_tb;
  localparam int PW = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00, host_rdata;
  logic       p1_tx_valid, p2_tx_valid, p1_tx_ready = 1'b0, p2_tx_ready = 1'b0;
  logic [7:0] p1_tx_data, p2_tx_data;
  logic       p1_rx_valid = 1'b0, p2_rx_valid = 1'b0, p1_rx_ready, p2_rx_ready;
  logic [7:0] p1_rx_data = 8'h00, p2_rx_data = 8'h00;
  logic       irq_p1, irq_p2;
  logic [7:0] ctrl_outport;
  logic [3:0] pulse_n;
  logic       selftest_ok = 1'b1, dev_timeout = 1'b0, dev_parity = 1'b0;
  logic [2:0] p1_line_code = 3'd0, p2_line_code = 3'd0;

  kbc_host_regs #(.PULSE_CYC(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .p1_tx_valid(p1_tx_valid), .p1_tx_ready(p1_tx_ready), .p1_tx_data(p1_tx_data),
    .p2_tx_valid(p2_tx_valid), .p2_tx_ready(p2_tx_ready), .p2_tx_data(p2_tx_data),
    .p1_rx_valid(p1_rx_valid), .p1_rx_ready(p1_rx_ready), .p1_rx_data(p1_rx_data),
    .p2_rx_valid(p2_rx_valid), .p2_rx_ready(p2_rx_ready), .p2_rx_data(p2_rx_data),
    .irq_p1(irq_p1), .irq_p2(irq_p2), .ctrl_outport(ctrl_outport), .pulse_n(pulse_n),
    .selftest_ok(selftest_ok), .p1_line_code(p1_line_code), .p2_line_code(p2_line_code),
    .dev_timeout(dev_timeout), .dev_parity(dev_parity)
  );

  int checks = 0, fails = 0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // pending kinds: 0 none, 1 ram write, 2 output port, 3 loop p1, 4 loop p2, 5 to p2
  bit         m_rxf, m_txf, m_tx2, m_last;
  logic [7:0] m_rxd, m_txd, m_out;
  int         m_src, m_pend, m_pidx, m_cnt;
  logic [7:0] m_ram [32];
  logic [3:0] m_act;
  bit         mr1, mr2, mcw, mdw, mdr;
  int         opend;
  logic [7:0] mresp, c;

  function automatic bit is_resp(input logic [7:0] v);
    return (v >= 8'h20 && v <= 8'h3F) || v == 8'hAA || v == 8'hAB || v == 8'hA9 || v == 8'hD0;
  endfunction
  function automatic bit is_known(input logic [7:0] v);
    return is_resp(v) || (v >= 8'h60 && v <= 8'h7F) || (v >= 8'hF0) ||
           v == 8'hAD || v == 8'hAE || v == 8'hA7 || v == 8'hA8 ||
           v == 8'hD1 || v == 8'hD2 || v == 8'hD3 || v == 8'hD4;
  endfunction
  function automatic int pend_of(input logic [7:0] v);
    if (v >= 8'h60 && v <= 8'h7F) return 1;
    if (v == 8'hD1) return 2;
    if (v == 8'hD2) return 3;
    if (v == 8'hD3) return 4;
    if (v == 8'hD4) return 5;
    return 0;
  endfunction
  function automatic logic [7:0] m_live();
    return {m_out[7:6], m_rxf && m_src == 2, m_rxf && m_src == 1, m_out[3:0]};
  endfunction
  function automatic bit m_ctrl();
    return (host_wr && host_addr == 8'h64 && is_resp(host_wdata)) ||
           (host_wr && host_addr == 8'h60 && (m_pend == 3 || m_pend == 4));
  endfunction
  function automatic bit m_r1();
    return m_ram[0][4] || (!m_rxf && !m_ctrl());
  endfunction
  function automatic bit m_r2();
    return m_ram[0][5] || (!m_rxf && !m_ctrl() && !(p1_rx_valid && !m_ram[0][4]));
  endfunction
  function automatic logic [7:0] m_rdata();
    if (host_addr == 8'h64)
      return {dev_parity, dev_timeout, 2'b00, m_last, m_ram[0][2], m_txf, m_rxf};
    if (host_addr == 8'h60) return m_rxd;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxf = 0; m_txf = 0; m_tx2 = 0; m_last = 0; m_rxd = 0; m_txd = 0;
      m_out = 8'h01; m_src = 0; m_pend = 0; m_pidx = 0; m_cnt = 0; m_act = 0;
      for (int i = 0; i < 32; i++) m_ram[i] = 8'h00;
    end else begin
      mr1 = m_r1(); mr2 = m_r2(); opend = m_pend; c = host_wdata;
      mcw = host_wr && host_addr == 8'h64;
      mdw = host_wr && host_addr == 8'h60;
      mdr = host_rd && host_addr == 8'h60;
      case (c)
        8'hAA:   mresp = selftest_ok ? 8'h55 : 8'hFC;
        8'hAB:   mresp = {5'b0, p1_line_code};
        8'hA9:   mresp = {5'b0, p2_line_code};
        8'hD0:   mresp = m_live();
        default: mresp = m_ram[c[4:0]];
      endcase
      if (mdw && (opend == 0 || opend == 5) && !m_txf) begin
        m_txf = 1; m_txd = c; m_tx2 = (opend == 5);
      end else if (m_txf && ((!m_tx2 && p1_tx_ready) || (m_tx2 && p2_tx_ready))) begin
        m_txf = 0;
      end
      if (mdr) m_rxf = 0;
      if (p1_rx_valid && mr1 && !m_ram[0][4]) begin
        m_rxf = 1; m_rxd = p1_rx_data; m_src = 1;
      end else if (p2_rx_valid && mr2 && !m_ram[0][5]) begin
        m_rxf = 1; m_rxd = p2_rx_data; m_src = 2;
      end
      if (mcw && is_resp(c)) begin
        m_rxf = 1; m_rxd = mresp; m_src = 0;
      end else if (mdw && (opend == 3 || opend == 4)) begin
        m_rxf = 1; m_rxd = c; m_src = opend - 2;
      end
      if (mdw && opend == 2) m_out = c;
      if (mdw && opend == 1) m_ram[m_pidx] = (m_pidx == 0) ? (c & 8'h77) : c;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_act = 4'h0;
      end
      if (mcw && is_known(c)) begin
        m_last = 1; m_pend = pend_of(c); m_pidx = int'(c[4:0]);
        if (c == 8'hAD) m_ram[0][4] = 1'b1;
        if (c == 8'hAE) m_ram[0][4] = 1'b0;
        if (c == 8'hA7) m_ram[0][5] = 1'b1;
        if (c == 8'hA8) m_ram[0][5] = 1'b0;
        if (c[7:4] == 4'hF && c[3:0] != 4'hF) begin
          m_act = ~c[3:0]; m_cnt = PW;
        end
      end else if (mdw) begin
        m_last = 0; m_pend = 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check({7'b0, irq_p1}, {7'b0, m_ram[0][0] && m_live()[4]}, "R9 irq_p1");
      check({7'b0, irq_p2}, {7'b0, m_ram[0][1] && m_live()[5]}, "R9 irq_p2");
      check(ctrl_outport, m_live(), "R7 outport");
      check({4'b0, pulse_n}, {4'b0, ~m_act}, "R10 pulse_n");
      check({7'b0, p1_tx_valid}, {7'b0, m_txf && !m_tx2}, "R2 p1_tx_valid");
      check({7'b0, p2_tx_valid}, {7'b0, m_txf && m_tx2}, "R3 p2_tx_valid");
      if (m_txf) check(m_tx2 ? p2_tx_data : p1_tx_data, m_txd, "R2 tx_data");
      check({7'b0, p1_rx_ready}, {7'b0, m_r1()}, "R11 p1_rx_ready");
      check({7'b0, p2_rx_ready}, {7'b0, m_r2()}, "R11 p2_rx_ready");
      check(host_rdata, m_rdata(), "R1 host_rdata");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk); v = host_rdata;
    tick();
    host_rd = 1'b0;
  endtask
  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    check(v, e, tag);
  endtask
  task automatic at_neg(input logic [7:0] act_sel, input logic [7:0] e, input string tag);
    check(act_sel, e, tag);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset status; R7 reset output port
    expect_rd(8'h64, 8'h00, "R1 reset status");
    @(negedge clk); check(ctrl_outport, 8'h01, "R7 reset outport");
    tick();

    // R2 data to port 1 with back-pressure
    wr(8'h60, 8'hAB);
    expect_rd(8'h64, 8'h02, "R2 tx full status");
    @(negedge clk); check({7'b0, p1_tx_valid}, 8'h01, "R2 p1 valid");
    check(p1_tx_data, 8'hAB, "R2 p1 data");
    tick();
    wr(8'h60, 8'hCD);
    @(negedge clk); check(p1_tx_data, 8'hAB, "R2 write while full dropped");
    tick();
    p1_tx_ready = 1'b1; tick(); p1_tx_ready = 1'b0;
    expect_rd(8'h64, 8'h00, "R2 tx emptied");

    // R3 redirect to port 2, R1 bit 3
    wr(8'h64, 8'hD4);
    expect_rd(8'h64, 8'h08, "R1 last write was command");
    wr(8'h60, 8'h5A);
    @(negedge clk); check({6'b0, p2_tx_valid, p1_tx_valid}, 8'h02, "R3 port 2 target");
    check(p2_tx_data, 8'h5A, "R3 port 2 data");
    tick();
    p2_tx_ready = 1'b1; tick(); p2_tx_ready = 1'b0;

    // R4 RAM access and config masking
    wr(8'h64, 8'h60); wr(8'h60, 8'hFF);
    wr(8'h64, 8'h20); expect_rd(8'h60, 8'h77, "R4 config masked");
    wr(8'h64, 8'h65); wr(8'h60, 8'h3C);
    wr(8'h64, 8'h25); expect_rd(8'h60, 8'h3C, "R4 ram byte 5");

    // R5 disabled port drops bytes
    p1_rx_valid = 1'b1; p1_rx_data = 8'h1C; tick(); p1_rx_valid = 1'b0;
    expect_rd(8'h64, 8'h0C, "R5 disabled port byte dropped");
    wr(8'h64, 8'hAE); wr(8'h64, 8'hA8);
    wr(8'h64, 8'h20); expect_rd(8'h60, 8'h47, "R5 ports enabled");

    // R9 interrupt, R7 live bit 4, R11 read clears
    p1_rx_valid = 1'b1; p1_rx_data = 8'h1C; tick(); p1_rx_valid = 1'b0;
    @(negedge clk); check({7'b0, irq_p1}, 8'h01, "R9 irq_p1 raised");
    check(ctrl_outport, 8'h11, "R7 port1 full bit");
    tick();
    expect_rd(8'h60, 8'h1C, "R11 data read");
    @(negedge clk); check({7'b0, irq_p1}, 8'h00, "R11 read clears irq");
    tick();

    // R11 port 1 priority, port 2 stalls until read
    p1_rx_valid = 1'b1; p1_rx_data = 8'h11; p2_rx_valid = 1'b1; p2_rx_data = 8'h22;
    tick(); p1_rx_valid = 1'b0;
    tick();
    expect_rd(8'h60, 8'h11, "R11 port 1 first");
    tick(); p2_rx_valid = 1'b0;
    @(negedge clk); check({7'b0, irq_p2}, 8'h01, "R9 irq_p2 raised");
    tick();
    expect_rd(8'h60, 8'h22, "R11 port 2 after");

    // R9 interrupt gated by config
    wr(8'h64, 8'h60); wr(8'h60, 8'h04);
    p2_rx_valid = 1'b1; p2_rx_data = 8'h33; tick(); p2_rx_valid = 1'b0;
    @(negedge clk); check({6'b0, irq_p2, irq_p1}, 8'h00, "R9 irq masked");
    check(ctrl_outport, 8'h21, "R7 port2 full bit");
    tick();
    expect_rd(8'h60, 8'h33, "R11 port 2 read");

    // R6 tests
    wr(8'h64, 8'hAA); expect_rd(8'h60, 8'h55, "R6 self test pass");
    selftest_ok = 1'b0;
    wr(8'h64, 8'hAA); expect_rd(8'h60, 8'hFC, "R6 self test fail");
    p1_line_code = 3'd3;
    wr(8'h64, 8'hAB); expect_rd(8'h60, 8'h03, "R6 port 1 line test");
    p2_line_code = 3'd0;
    wr(8'h64, 8'hA9); expect_rd(8'h60, 8'h00, "R6 port 2 line test");

    // R7 output port write/read
    wr(8'h64, 8'hD1); wr(8'h60, 8'hC3);
    @(negedge clk); check(ctrl_outport, 8'hC3, "R7 outport written");
    tick();
    wr(8'h64, 8'hD0); expect_rd(8'h60, 8'hC3, "R7 outport read");

    // R8 loopback
    wr(8'h64, 8'h60); wr(8'h60, 8'h03);
    wr(8'h64, 8'hD2); wr(8'h60, 8'h99);
    @(negedge clk); check({6'b0, irq_p2, irq_p1}, 8'h01, "R8 loop as port 1");
    tick();
    expect_rd(8'h60, 8'h99, "R8 loop data 1");
    wr(8'h64, 8'hD3); wr(8'h60, 8'h88);
    @(negedge clk); check({6'b0, irq_p2, irq_p1}, 8'h02, "R8 loop as port 2");
    tick();
    expect_rd(8'h60, 8'h88, "R8 loop data 2");

    // R10 pulse width
    wr(8'h64, 8'hFE);
    @(negedge clk); check({4'b0, pulse_n}, 8'h0E, "R10 pulse start");
    for (int i = 0; i < PW - 1; i++) tick();
    @(negedge clk); check({4'b0, pulse_n}, 8'h0E, "R10 pulse last cycle");
    tick();
    @(negedge clk); check({4'b0, pulse_n}, 8'h0F, "R10 pulse end");
    tick();
    wr(8'h64, 8'hF5);
    @(negedge clk); check({4'b0, pulse_n}, 8'h05, "R10 masked lines");
    for (int i = 0; i < PW + 2; i++) tick();
    wr(8'h64, 8'hFF);
    @(negedge clk); check({4'b0, pulse_n}, 8'h0F, "R10 all masked");
    tick();

    // R12 unknown commands
    wr(8'h64, 8'hD4); wr(8'h64, 8'hC5); wr(8'h60, 8'h11);
    @(negedge clk); check({6'b0, p2_tx_valid, p1_tx_valid}, 8'h02, "R12 pending kept");
    tick();
    p2_tx_ready = 1'b1; tick(); p2_tx_ready = 1'b0;
    wr(8'h64, 8'hC5);
    expect_rd(8'h64, 8'h00, "R12 status bit 3 unchanged");

    // R1 error flags
    dev_timeout = 1'b1; dev_parity = 1'b1;
    expect_rd(8'h64, 8'hC0, "R1 error flags");
    dev_timeout = 1'b0; dev_parity = 1'b0;
    repeat (4) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule